// File: doc/BRIEF.md
# Serial Port Request Controller

This block decides, for one serial channel, how FIFO servicing is signalled to the rest of the system. A control register written by software selects, separately for the transmit and receive directions, whether a FIFO condition produces a DMA request or a CPU interrupt. The register also gates a receive-error interrupt and selects which edges of the clear-to-send modem input set a latched status-change flag.

The transmit-space, receive-full, receive-timeout and error flags come from the FIFOs and the receiver. The block turns them into two DMA request levels and one interrupt level. The CTS pin is asynchronous. It is synchronised and edge-detected inside the block. The status-change flag stays set until software writes a one to clear it.

Top module: `sio_req_ctrl`

## Requirements
- R1: After reset, every control field reads 0, the CTS status-change flag is 0, and both DMA requests and the interrupt are low.
- R2: The control register has these fields: bit 15 transmit DMA enable, bit 14 receive DMA enable, bit 13 transmit-space interrupt enable, bit 12 receive interrupt enable, bit 11 error interrupt enable, bits 10:9 CTS edge condition. All other bits of `ctl_rdata_o` read 0. A write on `ctl_we_i` takes effect at that clock edge.
- R3: `tx_dma_req_o` is high exactly when the transmit DMA enable is 1 and `tx_space_i` is high, in the same cycle.
- R4: `rx_dma_req_o` is high exactly when the receive DMA enable is 1 and `rx_full_i` is high, in the same cycle.
- R5: With the transmit-space interrupt enable set, a high `tx_space_i` drives `irq_o` high.
- R6: With the receive interrupt enable set, a high `rx_full_i` or `rx_tout_i` drives `irq_o` high.
- R7: With the error interrupt enable set, any high bit of `err_i` drives `irq_o` high. Bit 0 is frame error, bit 1 is parity error and bit 2 is overrun.
- R8: The CTS condition uses 01 for rising edge, 10 for falling edge and 11 for both edges. When `cts_i` is sampled at clock edge k with a value different from its sample at edge k-1, and the edge direction matches the condition in force at edge k+2, `cts_chg_o` is high after edge k+2.
- R9: With the CTS condition at 00, no CTS transition sets `cts_chg_o`.
- R10: `cts_chg_o` stays set until `cts_clr_i` is high at a clock edge. If a qualifying edge is detected at the same clock edge, the flag stays set.
- R11: `irq_o` is the OR of the enabled sources in R5, R6 and R7 and of `cts_chg_o`. It has no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write data |
| ctl_rdata_o | output | 32 | Control register read value |
| cts_clr_i | input | 1 | Write-one-to-clear pulse for the CTS status-change flag |
| tx_space_i | input | 1 | Transmit FIFO has free space |
| rx_full_i | input | 1 | Receive data reached the fill level |
| rx_tout_i | input | 1 | Receive timeout flagged |
| err_i | input | 3 | Receive errors: frame, parity, overrun |
| cts_i | input | 1 | Raw asynchronous CTS pin |
| tx_dma_req_o | output | 1 | Transmit DMA request level |
| rx_dma_req_o | output | 1 | Receive DMA request level |
| irq_o | output | 1 | Interrupt request level |
| cts_chg_o | output | 1 | Latched CTS status-change flag |

## Verification
The assertions check on every cycle that each DMA request follows its enable and FIFO flag and that the reserved register bits stay zero. They also check that a set status-change flag holds until a clear, that it never rises while the condition field is 00, and that a set flag always raises the interrupt. The CTS timing needs the bench's reference model of pin history and condition: the three-edge latency, the choice of edge direction, and a clear that arrives at the same edge as a new qualifying edge. The bench also covers the combined interrupt under mixed enables and reconfiguration while inputs are active.

// File: rtl/sio_req_pkg.sv
package sio_req_pkg;
  localparam int unsigned TDE_BIT  = 15;
  localparam int unsigned RDE_BIT  = 14;
  localparam int unsigned TIE_BIT  = 13;
  localparam int unsigned RIE_BIT  = 12;
  localparam int unsigned EIE_BIT  = 11;
  localparam int unsigned COND_LSB = 9;
  localparam int unsigned COND_W   = 2;
  localparam int unsigned CTL_MSB  = TDE_BIT;

  typedef enum logic [COND_W-1:0] {
    CTS_NONE = 2'b00,
    CTS_RISE = 2'b01,
    CTS_FALL = 2'b10,
    CTS_BOTH = 2'b11
  } cts_cond_e;

  typedef struct packed {
    logic      tx_dma_en;
    logic      rx_dma_en;
    logic      tx_irq_en;
    logic      rx_irq_en;
    logic      err_irq_en;
    cts_cond_e cts_cond;
  } ctl_t;
endpackage

// File: rtl/sio_req_ctl_reg.sv
module sio_req_ctl_reg
  import sio_req_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output ctl_t          ctl_o,
  output logic [DW-1:0] rdata_o
);
  ctl_t ctl_q;
  ctl_t ctl_d;

  always_comb begin
    ctl_d            = ctl_q;
    if (we_i) begin
      ctl_d.tx_dma_en  = wdata_i[TDE_BIT];
      ctl_d.rx_dma_en  = wdata_i[RDE_BIT];
      ctl_d.tx_irq_en  = wdata_i[TIE_BIT];
      ctl_d.rx_irq_en  = wdata_i[RIE_BIT];
      ctl_d.err_irq_en = wdata_i[EIE_BIT];
      ctl_d.cts_cond   = cts_cond_e'(wdata_i[COND_LSB +: COND_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[TDE_BIT]            = ctl_q.tx_dma_en;
    rdata_o[RDE_BIT]            = ctl_q.rx_dma_en;
    rdata_o[TIE_BIT]            = ctl_q.tx_irq_en;
    rdata_o[RIE_BIT]            = ctl_q.rx_irq_en;
    rdata_o[EIE_BIT]            = ctl_q.err_irq_en;
    rdata_o[COND_LSB +: COND_W] = ctl_q.cts_cond;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/sio_req_cts_det.sv
module sio_req_cts_det
  import sio_req_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cts_i,
  input  cts_cond_e cond_i,
  input  logic      clr_i,
  output logic      chg_o
);
  logic [SYNC_STAGES:0] stage;
  logic                 prev_q;
  logic                 rise, fall, hit;
  logic                 chg_q;

  assign stage[0] = cts_i;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage[i+1] <= 1'b0;
      else         stage[i+1] <= stage[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage[SYNC_STAGES];
  end

  assign rise = stage[SYNC_STAGES] & ~prev_q;
  assign fall = ~stage[SYNC_STAGES] & prev_q;

  always_comb begin
    unique case (cond_i)
      CTS_RISE: hit = rise;
      CTS_FALL: hit = fall;
      CTS_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end

  // new edge beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    chg_q <= 1'b0;
    else if (hit)   chg_q <= 1'b1;
    else if (clr_i) chg_q <= 1'b0;
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/sio_req_route.sv
module sio_req_route
  import sio_req_pkg::*;
#(
  parameter int unsigned ERR_W = 3
) (
  input  ctl_t             ctl_i,
  input  logic             tx_space_i,
  input  logic             rx_full_i,
  input  logic             rx_tout_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             cts_chg_i,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o,
  output logic             irq_o
);
  localparam int unsigned NSRC = 4;
  logic [NSRC-1:0] src;

  assign tx_dma_req_o = ctl_i.tx_dma_en & tx_space_i;
  assign rx_dma_req_o = ctl_i.rx_dma_en & rx_full_i;

  assign src[0] = ctl_i.tx_irq_en & tx_space_i;
  assign src[1] = ctl_i.rx_irq_en & (rx_full_i | rx_tout_i);
  assign src[2] = ctl_i.err_irq_en & (|err_i);
  assign src[3] = cts_chg_i;

  assign irq_o = |src;
endmodule

// File: rtl/sio_req_ctrl.sv
module sio_req_ctrl
  import sio_req_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned ERR_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [DW-1:0]    ctl_wdata_i,
  output logic [DW-1:0]    ctl_rdata_o,
  input  logic             cts_clr_i,
  input  logic             tx_space_i,
  input  logic             rx_full_i,
  input  logic             rx_tout_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             cts_i,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o,
  output logic             irq_o,
  output logic             cts_chg_o
);
  ctl_t ctl;
  logic chg;

  sio_req_ctl_reg #(.DW(DW)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (ctl_rdata_o)
  );

  sio_req_cts_det #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cts_i  (cts_i),
    .cond_i (ctl.cts_cond),
    .clr_i  (cts_clr_i),
    .chg_o  (chg)
  );

  sio_req_route #(.ERR_W(ERR_W)) u_route (
    .ctl_i        (ctl),
    .tx_space_i   (tx_space_i),
    .rx_full_i    (rx_full_i),
    .rx_tout_i    (rx_tout_i),
    .err_i        (err_i),
    .cts_chg_i    (chg),
    .tx_dma_req_o (tx_dma_req_o),
    .rx_dma_req_o (rx_dma_req_o),
    .irq_o        (irq_o)
  );

  assign cts_chg_o = chg;
endmodule

// File: rtl/sio_req_ctrl_chk.sv
module sio_req_ctrl_chk
  import sio_req_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned ERR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DW-1:0]    ctl_rdata_o,
  input logic             cts_clr_i,
  input logic             tx_space_i,
  input logic             rx_full_i,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o,
  input logic             irq_o,
  input logic             cts_chg_o
);
  localparam logic [DW-1:0] RW_MASK = DW'(16'hFE00);

  AST_TX_DMA_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o == (ctl_rdata_o[TDE_BIT] & tx_space_i)); // R3

  AST_RX_DMA_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o == (ctl_rdata_o[RDE_BIT] & rx_full_i)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o & ~RW_MASK) == '0); // R2

  AST_CHG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_chg_o && !cts_clr_i) |=> cts_chg_o); // R10

  AST_NO_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cts_chg_o && ctl_rdata_o[COND_LSB +: COND_W] == 2'b00) |=> !cts_chg_o); // R9

  AST_CHG_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_chg_o |-> irq_o); // R11
endmodule

bind sio_req_ctrl sio_req_ctrl_chk #(.DW(DW), .ERR_W(ERR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_rdata_o  (ctl_rdata_o),
  .cts_clr_i    (cts_clr_i),
  .tx_space_i   (tx_space_i),
  .rx_full_i    (rx_full_i),
  .tx_dma_req_o (tx_dma_req_o),
  .rx_dma_req_o (rx_dma_req_o),
  .irq_o        (irq_o),
  .cts_chg_o    (cts_chg_o)
);

// File: tb/sio_req_ctrl_bench.sv
`timescale 1ns/1ps
module sio_req_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic [31:0] ctl_wdata_i = '0;
  logic [31:0] ctl_rdata_o;
  logic        cts_clr_i = 1'b0;
  logic        tx_space_i = 1'b0;
  logic        rx_full_i = 1'b0;
  logic        rx_tout_i = 1'b0;
  logic [2:0]  err_i = '0;
  logic        cts_i = 1'b0;
  logic        tx_dma_req_o, rx_dma_req_o, irq_o, cts_chg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_reg = '0;
  logic        m_chg = 1'b0;
  logic        h1 = 0, h2 = 0, h3 = 0;

  always #10 clk_i = ~clk_i;

  sio_req_ctrl u_sio_req_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return (m_reg[13] & tx_space_i) | (m_reg[12] & (rx_full_i | rx_tout_i)) |
           (m_reg[11] & (|err_i)) | m_chg;
  endfunction

  function automatic logic edge_hit(input logic [1:0] cond, input logic now_v, input logic old_v);
    case (cond)
      2'b01:   return now_v & ~old_v;
      2'b10:   return ~now_v & old_v;
      2'b11:   return now_v ^ old_v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_all();
    #1;
    check("R2", ctl_rdata_o, m_reg);
    check("R3", tx_dma_req_o, m_reg[15] & tx_space_i);
    check("R4", rx_dma_req_o, m_reg[14] & rx_full_i);
    check("R5 R6 R7 R11", irq_o, exp_irq());
    check("R8 R10", cts_chg_o, m_chg);
  endtask

  // advance one clock, updating the reference with the inputs now applied
  task automatic step();
    logic hit;
    hit = edge_hit(m_reg[10:9], h2, h3);
    m_chg = hit ? 1'b1 : (cts_clr_i ? 1'b0 : m_chg);
    h3 = h2; h2 = h1; h1 = cts_i;
    if (ctl_we_i) m_reg = ctl_wdata_i & 32'h0000_FE00;
    @(posedge clk_i);
    @(negedge clk_i);
    ctl_we_i  = 1'b0;
    cts_clr_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    tx_space_i = 1; rx_full_i = 1; rx_tout_i = 1; err_i = 3'b111;
    #1;
    check("R1", ctl_rdata_o, 32'h0);
    check("R1", {tx_dma_req_o, rx_dma_req_o, irq_o, cts_chg_o}, 4'b0000);

    // R9: condition 00 ignores toggles
    ctl_we_i = 1; ctl_wdata_i = 32'hFFFF_F9FF;
    step();
    check_all();
    for (int i = 0; i < 8; i++) begin
      cts_i = ~cts_i;
      step();
      check("R9", cts_chg_o, 1'b0);
    end
    // R8: rising only, measured latency
    ctl_we_i = 1; ctl_wdata_i = 32'h0000_0200;
    step();
    cts_i = 1'b0;
    repeat (4) step();
    cts_i = 1'b1;
    step(); step();
    check("R8", cts_chg_o, 1'b0);
    step();
    check("R8", cts_chg_o, 1'b1);
    // R10: clear at the same edge as a new edge keeps it set
    ctl_we_i = 1; ctl_wdata_i = 32'h0000_0600;
    step();
    cts_clr_i = 1; step();
    check("R10", cts_chg_o, 1'b0);
    cts_i = 1'b0;
    step(); step();
    cts_clr_i = 1; step();
    check("R10", cts_chg_o, 1'b1);

    for (int n = 0; n < 4000; n++) begin
      tx_space_i = $urandom_range(0, 1);
      rx_full_i  = ($urandom_range(0, 3) == 0);
      rx_tout_i  = ($urandom_range(0, 5) == 0);
      err_i      = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      if ($urandom_range(0, 4) == 0) cts_i = ~cts_i;
      cts_clr_i  = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) begin
        ctl_we_i = 1; ctl_wdata_i = $urandom;
      end
      check_all();
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule